// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single-word requests from an internal requester into cycles on a 16-bit external bus. On that bus the address and the data share the same AD lines. Each request carries an address, write data, per-byte enables, a read/write flag and a narrow flag that selects an 8-bit data phase. Before starting a cycle, the block decides whether the address belongs to on-chip memory or to the external bus. That decision uses a fixed address map and an external-access pin that is sampled while reset is held.

For an external access the block produces a three-state bus cycle:

- An address state, in which an active-high latch strobe pulses.
- A data state.
- A late data state.

An active-low address-valid strobe covers all three states. The read strobe and the write strobe assert only for external reads and external writes respectively. A live configuration input selects what the write strobe means: either every write, or only writes that touch the low byte. Read data is captured from the bus at the end of the late state and returned with a one-cycle done pulse. That done cycle doubles as the bus idle state, so back-to-back requests give one external cycle every four states. An internal access produces no bus activity and finishes with a done pulse on the next cycle.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, ale=0, adv_n=1, rd_n=1, wr_n=1, busy=0, done=0 and ad_oe=2'b00.
- R2: In the first state after an external request is accepted (T1), ale=1, adv_n=0, ad_oe=2'b11 and ad_out equals the full 16-bit address. In T2 and T3, ale=0.
- R3: adv_n is low in T1, T2 and T3 and high in the following cycle. In that following cycle done=1 and done_ext=1 for exactly one cycle. A request presented in that done cycle starts the next T1 one cycle later, so the cycle period is four states.
- R4: For a 16-bit read, ad_oe=2'b00 in T2 and T3. rd_n is high in T2 and low in T3, so the lines are released one state before the read strobe. ad_in is sampled at the clock edge that ends T3. rdata shows the sample in the done cycle.
- R5: For a 16-bit write, ad_oe=2'b11 and ad_out equals the write data in T2 and T3.
- R6: For a narrow (8-bit) access, lane 1 (ad_out[15:8]) keeps driving the address high byte in T2 and T3. A narrow read floats only lane 0 (ad_oe=2'b10). The read result is the sampled ad_in[7:0] copied into both bytes of rdata.
- R7: For a narrow write, ad_out[7:0] carries the write byte of the lowest set byte enable: bit 0 selects wdata[7:0] and bit 1 alone selects wdata[15:8].
- R8: With cfg_wr_mode=1, wr_n is low in T2 and T3 of every external write.
- R9: With cfg_wr_mode=0, wr_n is low in T2 and T3 only for narrow writes and for 16-bit writes with byte enable bit 0 set. A 16-bit high-byte-only write leaves wr_n high.
- R10: rd_n is low only in T3 of external reads. wr_n is low only during external writes. The two are never low together.
- R11: Addresses 8000h–FFFFh and 0300h–1EFFh are external. Addresses 2000h–7FFFh are external when the latched access pin is 0 and internal when it is 1. All other addresses are internal. An internal access gives done=1 and done_ext=0 in the cycle after acceptance, with ale=0 and adv_n=1.
- R12: The access pin is latched on the clock edges that occur while rst_n is low. Changing it after reset has no effect on routing.
- R13: busy is 1 in T1, T2 and T3 and 0 otherwise. A request presented while busy is ignored and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one period per state time |
| rst_n | input | 1 | Active-low reset |
| ea_pin | input | 1 | External-access select, latched during reset |
| cfg_wr_mode | input | 1 | 1: write strobe on every write; 0: low-byte write strobe |
| req | input | 1 | Request valid, accepted when not busy |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Request write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_narrow | input | 1 | 1 = 8-bit data phase |
| busy | output | 1 | External cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ext | output | 1 | Completed access went to the external bus |
| rdata | output | 16 | Read result, valid with done |
| ad_out | output | 16 | Value driven on the AD lines |
| ad_oe | output | 2 | Per-byte-lane output enable of AD |
| ad_in | input | 16 | Value seen on the AD lines |
| ale | output | 1 | Address latch strobe, active high |
| adv_n | output | 1 | Address valid, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench drives every input just after a falling edge, so the accepting rising edge falls mid-period. T1 is observed at the next falling edge, T2 and T3 one and two periods later, and the done cycle three periods after T1. An internal access is checked for done one period after the request. Read data is placed on ad_in at the falling edge inside T3, which is ahead of the capturing edge, and it is compared in the done cycle. Each transfer starts in the done cycle of the previous one, so the random run also checks that the period is four states. The injected-request test looks at the bus one extra period after done to confirm that no cycle started.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_LATE = 2'd3
   } xbus_phase_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/xbus_route.sv
`timescale 1ns/1ps
module xbus_route #(
   parameter int unsigned AW = 16,
   parameter logic [AW-1:0] SHARED_LO = 16'h2000,
   parameter logic [AW-1:0] SHARED_HI = 16'h7FFF,
   parameter logic [AW-1:0] UPPER_LO  = 16'h8000,
   parameter logic [AW-1:0] GAP_LO    = 16'h0300,
   parameter logic [AW-1:0] GAP_HI    = 16'h1EFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ea_pin,
   input  logic [AW-1:0] addr,
   output logic          go_ext
);
   logic ea_q;
   logic in_shared, in_upper, in_gap;

   generate
      if (SHARED_LO > SHARED_HI) begin : g_bad_shared
         $error("xbus_route: shared window bounds reversed");
      end
      if (GAP_LO > GAP_HI) begin : g_bad_gap
         $error("xbus_route: gap window bounds reversed");
      end
   endgenerate

   // access pin is sampled on every edge seen while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) ea_q <= ea_pin;
   end

   always_comb begin
      in_shared = (addr >= SHARED_LO) && (addr <= SHARED_HI);
      in_upper  = (addr >= UPPER_LO);
      in_gap    = (addr >= GAP_LO) && (addr <= GAP_HI);
      go_ext    = in_upper || in_gap || (in_shared && !ea_q);
   end

   always_comb begin
      if (rst_n && in_upper) assert_upper_ext_R11: assert (go_ext);
   end
endmodule

// File: rtl/xbus_strobe.sv
`timescale 1ns/1ps
module xbus_strobe #(
   parameter int unsigned NL = 2
) (
   input  logic          wr_mode,
   input  logic          narrow,
   input  logic [NL-1:0] be,
   output logic          wr_qual
);
   generate
      if (NL == 1) begin : g_single
         // one lane: every write is a low-byte write
         logic unused_ok;
         assign unused_ok = wr_mode ^ narrow ^ be[0];
         assign wr_qual   = 1'b1;
      end else begin : g_multi
         always_comb begin
            wr_qual = wr_mode | narrow | be[0];
         end
      end
   endgenerate
endmodule

// File: rtl/xbus_lanes.sv
`timescale 1ns/1ps
module xbus_lanes import xbus_pkg::*; #(
   parameter int unsigned DW = 16,
   localparam int unsigned NL = DW / LANE_W
) (
   input  xbus_phase_e   phase,
   input  logic [DW-1:0] q_addr,
   input  logic [DW-1:0] q_wdata,
   input  logic [NL-1:0] q_be,
   input  logic          q_we,
   input  logic          q_narrow,
   output logic [DW-1:0] ad_out,
   output logic [NL-1:0] ad_oe
);
   logic [LANE_W-1:0] narrow_byte;

   // lowest enabled byte feeds lane 0 on a narrow write
   always_comb begin
      narrow_byte = q_wdata[LANE_W-1:0];
      for (int i = NL - 1; i >= 0; i--) begin
         if (q_be[i]) narrow_byte = q_wdata[i*LANE_W +: LANE_W];
      end
   end

   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic [LANE_W-1:0] lane_o;
      logic              lane_e;
      always_comb begin
         lane_o = '0;
         lane_e = 1'b0;
         unique case (phase)
            PH_ADDR: begin
               lane_o = q_addr[g*LANE_W +: LANE_W];
               lane_e = 1'b1;
            end
            PH_DATA, PH_LATE: begin
               if (q_narrow && (g != 0)) begin
                  lane_o = q_addr[g*LANE_W +: LANE_W];
                  lane_e = 1'b1;
               end else if (q_we) begin
                  lane_o = q_narrow ? narrow_byte : q_wdata[g*LANE_W +: LANE_W];
                  lane_e = 1'b1;
               end
            end
            default: begin
               lane_o = '0;
               lane_e = 1'b0;
            end
         endcase
      end
      assign ad_out[g*LANE_W +: LANE_W] = lane_o;
      assign ad_oe[g]                   = lane_e;
   end
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq import xbus_pkg::*; #(
   parameter int unsigned DW = 16,
   localparam int unsigned NL = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NL-1:0] req_be,
   input  logic          req_we,
   input  logic          req_narrow,
   input  logic          go_ext,
   input  logic [DW-1:0] ad_in,
   input  logic          wr_qual,
   output xbus_phase_e   phase,
   output logic [DW-1:0] q_addr,
   output logic [DW-1:0] q_wdata,
   output logic [NL-1:0] q_be,
   output logic          q_we,
   output logic          q_narrow,
   output logic          busy,
   output logic          done,
   output logic          done_ext,
   output logic [DW-1:0] rdata,
   output logic          ale,
   output logic          adv_n,
   output logic          rd_n,
   output logic          wr_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         q_addr   <= '0;
         q_wdata  <= '0;
         q_be     <= '0;
         q_we     <= 1'b0;
         q_narrow <= 1'b0;
         done     <= 1'b0;
         done_ext <= 1'b0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (req) begin
               q_addr   <= req_addr;
               q_wdata  <= req_wdata;
               q_be     <= req_be;
               q_we     <= req_we;
               q_narrow <= req_narrow;
               if (go_ext) begin
                  phase <= PH_ADDR;
               end else begin
                  done     <= 1'b1;
                  done_ext <= 1'b0;
               end
            end
            PH_ADDR: phase <= PH_DATA;
            PH_DATA: phase <= PH_LATE;
            PH_LATE: begin
               phase    <= PH_IDLE;
               done     <= 1'b1;
               done_ext <= 1'b1;
               if (!q_we) rdata <= q_narrow ? {NL{ad_in[LANE_W-1:0]}} : ad_in;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy  = (phase != PH_IDLE);
   assign ale   = (phase == PH_ADDR);
   assign adv_n = (phase == PH_IDLE);
   assign rd_n  = !((phase == PH_LATE) && !q_we);
   assign wr_n  = !(((phase == PH_DATA) || (phase == PH_LATE)) && q_we && wr_qual);

   assert_ale_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !adv_n);
   assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (!ale && !adv_n));
   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_ext) |-> (adv_n && !busy && $past(!adv_n)));
   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   assert_no_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !ale);
endmodule

// File: rtl/xbus_cycle_ctrl.sv
`timescale 1ns/1ps
module xbus_cycle_ctrl import xbus_pkg::*; #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16,
   localparam int unsigned NL = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ea_pin,
   input  logic          cfg_wr_mode,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NL-1:0] req_be,
   input  logic          req_we,
   input  logic          req_narrow,
   output logic          busy,
   output logic          done,
   output logic          done_ext,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] ad_out,
   output logic [NL-1:0] ad_oe,
   input  logic [DW-1:0] ad_in,
   output logic          ale,
   output logic          adv_n,
   output logic          rd_n,
   output logic          wr_n
);
   generate
      if (DW % LANE_W != 0) begin : g_bad_dw
         $error("xbus_cycle_ctrl: data width must be whole bytes");
      end
      if (AW != DW) begin : g_bad_aw
         $error("xbus_cycle_ctrl: address and data share the AD lines");
      end
   endgenerate

   xbus_phase_e   phase;
   logic [DW-1:0] q_addr, q_wdata;
   logic [NL-1:0] q_be;
   logic          q_we, q_narrow, go_ext, wr_qual;

   xbus_route #(.AW(AW)) u_route (
      .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .addr(req_addr), .go_ext(go_ext)
   );

   xbus_strobe #(.NL(NL)) u_strobe (
      .wr_mode(cfg_wr_mode), .narrow(q_narrow), .be(q_be), .wr_qual(wr_qual)
   );

   xbus_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_we(req_we),
      .req_narrow(req_narrow), .go_ext(go_ext), .ad_in(ad_in),
      .wr_qual(wr_qual), .phase(phase), .q_addr(q_addr), .q_wdata(q_wdata),
      .q_be(q_be), .q_we(q_we), .q_narrow(q_narrow), .busy(busy),
      .done(done), .done_ext(done_ext), .rdata(rdata), .ale(ale),
      .adv_n(adv_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   xbus_lanes #(.DW(DW)) u_lanes (
      .phase(phase), .q_addr(q_addr), .q_wdata(q_wdata), .q_be(q_be),
      .q_we(q_we), .q_narrow(q_narrow), .ad_out(ad_out), .ad_oe(ad_oe)
   );

   // lane 0 must already be released the state before the read strobe falls
   assert_float_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> (!ad_oe[0] && $past(!ad_oe[0])));
endmodule

// File: tb/xbus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_cycle_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ea_pin = 1'b1;
   logic        cfg_wr_mode = 1'b1;
   logic        req = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_we = 1'b0;
   logic        req_narrow = 1'b0;
   logic        busy, done, done_ext, ale, adv_n, rd_n, wr_n;
   logic [15:0] rdata, ad_out;
   logic [15:0] ad_in = '0;
   logic [1:0]  ad_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit ea_model = 1'b1;

   always #2.5 clk = ~clk;

   xbus_cycle_ctrl u_xbus_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .cfg_wr_mode(cfg_wr_mode),
      .req(req), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_we(req_we), .req_narrow(req_narrow), .busy(busy), .done(done),
      .done_ext(done_ext), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .ale(ale), .adv_n(adv_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_ext(input logic [15:0] a, input bit ea);
      if (a >= 16'h8000) return 1'b1;
      if (a >= 16'h0300 && a <= 16'h1EFF) return 1'b1;
      if (a >= 16'h2000 && a <= 16'h7FFF) return !ea;
      return 1'b0;
   endfunction

   function automatic logic [1:0] exp_oe(input bit we, input bit w8);
      return {w8 | we, we};
   endfunction

   function automatic logic [15:0] exp_bus(input logic [15:0] a, input logic [15:0] wd,
                                           input logic [1:0] be, input bit we, input bit w8);
      logic [7:0] nb;
      nb = be[0] ? wd[7:0] : (be[1] ? wd[15:8] : wd[7:0]);
      if (w8) return {a[15:8], we ? nb : 8'h00};
      return we ? wd : 16'h0000;
   endfunction

   function automatic logic [15:0] lane_mask(input logic [1:0] oe);
      return {{8{oe[1]}}, {8{oe[0]}}};
   endfunction

   // starts on a falling edge; ends on the falling edge inside the done cycle
   task automatic xfer(input logic [15:0] a, input logic [15:0] wd, input logic [1:0] be,
                       input bit we, input bit w8, input bit inj);
      bit ext, strb;
      logic [15:0] eb, rv, m;
      logic [1:0] eo;
      ext  = exp_ext(a, ea_model);
      strb = we && (cfg_wr_mode || w8 || be[0]);
      eb   = exp_bus(a, wd, be, we, w8);
      eo   = exp_oe(we, w8);
      m    = lane_mask(eo);
      req = 1'b1; req_addr = a; req_wdata = wd; req_be = be; req_we = we; req_narrow = w8;
      @(negedge clk);
      req = 1'b0;
      if (!ext) begin
         chk(done && !done_ext && !ale && adv_n && rd_n && wr_n, "R11 internal done",
             {27'd0, done, done_ext, ale, adv_n, rd_n}, {27'd0, 5'b10011});
         return;
      end
      // T1
      chk(ale && !adv_n && ad_oe == 2'b11 && ad_out == a, "R2 address state",
          {ale, adv_n, ad_oe, ad_out}, {1'b1, 1'b0, 2'b11, a});
      chk(busy && rd_n && wr_n, "R13 busy in T1", {busy, rd_n, wr_n}, 3'b111);
      if (inj) begin
         req = 1'b1; req_addr = 16'h8123; req_we = 1'b0;
      end
      @(negedge clk);
      req = 1'b0;
      // T2
      chk(!ale && !adv_n && busy, "R3 T2 strobes", {ale, adv_n, busy}, 3'b001);
      chk(ad_oe == eo && (ad_out & m) == (eb & m), we ? "R5 R7 T2 write data" : "R6 T2 read lanes",
          {ad_oe, ad_out & m}, {eo, eb & m});
      chk(rd_n == 1'b1, "R4 no read strobe in T2", rd_n, 1);
      chk(wr_n == !strb, cfg_wr_mode ? "R8 T2 write strobe" : "R9 T2 write strobe", wr_n, !strb);
      @(negedge clk);
      // T3
      rv = 16'($urandom);
      ad_in = rv;
      chk(!adv_n && busy && !ale, "R3 T3 valid", {ale, adv_n, busy}, 3'b001);
      chk(rd_n == we, "R10 read strobe T3", rd_n, we);
      chk(wr_n == !strb, cfg_wr_mode ? "R8 T3 write strobe" : "R9 T3 write strobe", wr_n, !strb);
      chk(ad_oe == eo && (ad_out & m) == (eb & m), "R4 R6 T3 lanes",
          {ad_oe, ad_out & m}, {eo, eb & m});
      @(negedge clk);
      // done cycle
      chk(done && done_ext && adv_n && !busy && rd_n && wr_n && ad_oe == 2'b00,
          "R3 done cycle", {done, done_ext, adv_n, busy, rd_n, wr_n, ad_oe},
          8'b1110_1100);
      if (!we)
         chk(rdata == (w8 ? {rv[7:0], rv[7:0]} : rv), w8 ? "R6 narrow read" : "R4 read data",
             rdata, w8 ? {rv[7:0], rv[7:0]} : rv);
      if (inj) begin
         @(negedge clk);
         chk(!ale && adv_n && !done, "R13 busy request ignored", {ale, adv_n, done}, 3'b010);
      end
   endtask

   task automatic do_reset(input bit ea);
      rst_n = 1'b0;
      ea_pin = ea;
      ea_model = ea;
      repeat (3) @(negedge clk);
      chk(!ale && adv_n && rd_n && wr_n && !busy && !done && ad_oe == 2'b00,
          "R1 reset state", {ale, adv_n, rd_n, wr_n, busy, done, ad_oe}, 8'b0111_0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ale && adv_n && !busy && !done, "R1 idle after reset",
          {ale, adv_n, busy, done}, 4'b0100);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset(1'b1);
      cfg_wr_mode = 1'b1;
      xfer(16'h8000, 16'hA55A, 2'b11, 1'b1, 1'b0, 1'b0);  // R5 R8
      xfer(16'h0300, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0);  // R4 R11 gap low edge
      xfer(16'h1EFF, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0);  // R11 gap high edge
      xfer(16'h2000, 16'h1111, 2'b11, 1'b1, 1'b0, 1'b0);  // R11 shared, internal
      xfer(16'h1F00, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0);  // R11 internal
      xfer(16'h02FF, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0);  // R11 internal
      ea_pin = 1'b0;                                      // R12 no effect
      xfer(16'h7FFF, 16'h2222, 2'b11, 1'b1, 1'b0, 1'b0);
      cfg_wr_mode = 1'b0;
      xfer(16'h9000, 16'hBEEF, 2'b10, 1'b1, 1'b0, 1'b0);  // R9 high-only: no strobe
      xfer(16'h9002, 16'hBEEF, 2'b01, 1'b1, 1'b0, 1'b0);  // R9 low byte
      xfer(16'h9004, 16'hCAFE, 2'b11, 1'b1, 1'b0, 1'b0);  // R9 word
      xfer(16'hA001, 16'h7C3E, 2'b10, 1'b1, 1'b1, 1'b0);  // R7 R9 narrow high byte
      xfer(16'hA002, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b0);  // R6 narrow read
      xfer(16'hC000, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b1);  // R13 injected request
      do_reset(1'b0);
      xfer(16'h2000, 16'h3333, 2'b11, 1'b1, 1'b0, 1'b0);  // R11 R12 shared external
      xfer(16'h7FFF, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 80; i++) begin
         logic [15:0] a;
         logic [1:0]  be;
         a  = 16'($urandom);
         be = 2'($urandom_range(1, 3));
         cfg_wr_mode = 1'($urandom);
         xfer(a, 16'($urandom), be, 1'($urandom), 1'($urandom), 1'b0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule